// File: doc/BRIEF.md
# Multi-mode LCD timing generator

This block produces the raster timing for a parallel RGB TFT panel. It creates a horizontal sync, a vertical sync, a data-enable strobe and the current pixel coordinates, one pixel for each pixel clock. A 3-bit resolution code picks one of five built-in timing sets. Each set fixes the active size, front porch, sync width and back porch on both axes. All outputs are registered and change on the rising pixel clock edge.

The resolution code is read only when the raster reaches the last pixel of the last line of a frame, so a mode change never breaks up a frame. Code 1 asks for a 480x272 picture that is doubled to a larger panel. The block treats it as the plain 480x272 timing and reports the aliased code. Codes 2 and 3 have no timing set. When one of them is sampled, the block raises an error flag and keeps the mode it already has. A standby input blanks the outputs and parks the raster at the origin. While standby is held, the code is read on every cycle, so a mode chosen during standby applies to the first frame after release.

Top module: `lcd_timing_gen`

## Requirements
- R1: While rst_ni is low, de_o, hsync_o and vsync_o are 0, x_o and y_o are 0, active_mode_o is 7 and mode_err_o is 0.
- R2: On the first rising edge after reset or standby is released, the outputs describe pixel (0,0). After that, x_o steps by one on each edge and wraps to 0 after the last column of the line total, and y_o steps when x_o wraps and returns to 0 after the last line of the frame total.
- R3: de_o is 1 exactly when x_o is below the active width and y_o is below the active height of the current mode.
- R4: hsync_o is 1 (active high) for the sync width in pixels, starting at x_o = active width + horizontal front porch.
- R5: vsync_o is 1 (active high) for whole lines, over the sync width in lines, starting at y_o = active height + vertical front porch.
- R6: The timing sets, given as active/front porch/sync/back porch, horizontal then vertical, are: code 7: 800/40/1/216 and 480/10/1/35; code 6: 640/24/1/136 and 480/18/1/27; code 5: 480/2/1/43 and 272/2/1/12; code 4: 480/2/1/43 and 640/4/1/8; code 0: 400/20/1/108 and 240/2/1/20. active_mode_o reports the code in use.
- R7: A sampled code 1 selects the code 5 timing, and active_mode_o then reads 5.
- R8: A sampled code 2 or 3 sets mode_err_o to 1 and leaves active_mode_o and the timing unchanged.
- R9: Outside standby, mode_code_i is sampled only on the edge that outputs the last pixel of the frame. Changes at any other time leave active_mode_o, mode_err_o and the raster unchanged.
- R10: On each edge where standby_i is 1, de_o, hsync_o and vsync_o go to 0, x_o and y_o go to 0, and mode_code_i is sampled.
- R11: A sampled legal code clears mode_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_code_i | input | 3 | Requested resolution code |
| standby_i | input | 1 | Blank outputs and park the raster at the origin |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable, high on visible pixels |
| x_o | output | 11 | Current column |
| y_o | output | 11 | Current line |
| mode_err_o | output | 1 | Last sampled code was illegal |
| active_mode_o | output | 3 | Code of the timing set in use |

## Verification
Every legal code is selected through standby and run for one or two lines. This separates the five horizontal timings by line length, by the position of the data-enable edge and by the position of the sync pulse. One complete frame of the smallest mode checks the vertical porch, the vertical sync line and the frame wrap. During that frame, a legal code applied mid-frame and an illegal code present at the boundary together separate boundary-only sampling from immediate sampling. Codes 1, 2 and 3, followed by a legal code, test the aliasing and the error flag's set, hold and clear behaviour. A standby pulse in the middle of a line, with a code change inside it, shows that the raster is parked and restarts at the origin.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  localparam int unsigned CW = 11;
  localparam int unsigned MW = 3;

  typedef logic [CW-1:0] coord_t;
  typedef logic [MW-1:0] mode_t;

  typedef struct packed {
    coord_t act;
    coord_t fp;
    coord_t sw;
    coord_t bp;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } timing_t;

  localparam mode_t MODE_W800_H480 = 3'd7;
  localparam mode_t MODE_W640_H480 = 3'd6;
  localparam mode_t MODE_W480_H272 = 3'd5;
  localparam mode_t MODE_W480_H640 = 3'd4;
  localparam mode_t MODE_W480_DBL  = 3'd1;
  localparam mode_t MODE_W400_H240 = 3'd0;

  function automatic logic mode_legal(mode_t c);
    return !(c == 3'd2 || c == 3'd3);
  endfunction

  function automatic mode_t mode_alias(mode_t c);
    return (c == MODE_W480_DBL) ? MODE_W480_H272 : c;
  endfunction

  function automatic axis_t mk_axis(int a, int f, int s, int b);
    axis_t r;
    r.act = coord_t'(a);
    r.fp  = coord_t'(f);
    r.sw  = coord_t'(s);
    r.bp  = coord_t'(b);
    return r;
  endfunction

  function automatic timing_t mode_timing(mode_t c);
    timing_t t;
    case (c)
      MODE_W640_H480: begin
        t.h = mk_axis(640, 24, 1, 136);
        t.v = mk_axis(480, 18, 1, 27);
      end
      MODE_W480_H272: begin
        t.h = mk_axis(480, 2, 1, 43);
        t.v = mk_axis(272, 2, 1, 12);
      end
      MODE_W480_H640: begin
        t.h = mk_axis(480, 2, 1, 43);
        t.v = mk_axis(640, 4, 1, 8);
      end
      MODE_W400_H240: begin
        t.h = mk_axis(400, 20, 1, 108);
        t.v = mk_axis(240, 2, 1, 20);
      end
      default: begin
        t.h = mk_axis(800, 40, 1, 216);
        t.v = mk_axis(480, 10, 1, 35);
      end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/lcd_mode_sel.sv
module lcd_mode_sel
  import lcd_timing_pkg::*;
#(
  parameter mode_t RESET_MODE = MODE_W800_H480
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sample_i,
  input  mode_t   code_i,
  output mode_t   mode_o,
  output logic    err_o,
  output timing_t timing_o
);

  mode_t mode_q;
  logic  err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RESET_MODE;
      err_q  <= 1'b0;
    end else if (sample_i) begin
      if (mode_legal(code_i)) begin
        mode_q <= mode_alias(code_i);
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  assign mode_o   = mode_q;
  assign err_o    = err_q;
  assign timing_o = mode_timing(mode_q);

endmodule

// File: rtl/lcd_axis_cnt.sv
module lcd_axis_cnt
  import lcd_timing_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   adv_i,
  input  axis_t  cfg_i,
  output coord_t cnt_o,
  output logic   last_o,
  output logic   active_o,
  output logic   sync_o
);

  coord_t cnt_q;
  coord_t sync_beg;
  coord_t sync_end;
  coord_t total;

  always_comb begin
    sync_beg = cfg_i.act + cfg_i.fp;
    sync_end = sync_beg + cfg_i.sw;
    total    = sync_end + cfg_i.bp;
  end

  assign last_o   = (cnt_q == total - coord_t'(1));
  assign active_o = (cnt_q < cfg_i.act);
  assign sync_o   = (cnt_q >= sync_beg) && (cnt_q < sync_end);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (adv_i)   cnt_q <= last_o ? '0 : cnt_q + coord_t'(1);
  end

endmodule

// File: rtl/lcd_out_reg.sv
module lcd_out_reg
  import lcd_timing_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   blank_i,
  input  logic   h_act_i,
  input  logic   v_act_i,
  input  logic   h_sync_i,
  input  logic   v_sync_i,
  input  coord_t x_i,
  input  coord_t y_i,
  output logic   de_o,
  output logic   hsync_o,
  output logic   vsync_o,
  output coord_t x_o,
  output coord_t y_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o    <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
    end else if (blank_i) begin
      de_o    <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      de_o    <= h_act_i && v_act_i;
      hsync_o <= h_sync_i;
      vsync_o <= v_sync_i;
      x_o     <= x_i;
      y_o     <= y_i;
    end
  end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter mode_t RESET_MODE = MODE_W800_H480
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MW-1:0] mode_code_i,
  input  logic          standby_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          mode_err_o,
  output logic [MW-1:0] active_mode_o
);

  timing_t timing;
  coord_t  h_cnt, v_cnt;
  logic    h_last, v_last, h_act, v_act, h_sync, v_sync;
  logic    frame_last;
  logic    v_adv;

  // frame boundary only counts while running; standby samples every cycle
  assign frame_last = h_last && v_last && !standby_i;
  assign v_adv      = h_last && !standby_i;

  lcd_mode_sel #(.RESET_MODE(RESET_MODE)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (frame_last || standby_i),
    .code_i   (mode_code_i),
    .mode_o   (active_mode_o),
    .err_o    (mode_err_o),
    .timing_o (timing)
  );

  lcd_axis_cnt u_hcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (standby_i),
    .adv_i    (!standby_i),
    .cfg_i    (timing.h),
    .cnt_o    (h_cnt),
    .last_o   (h_last),
    .active_o (h_act),
    .sync_o   (h_sync)
  );

  lcd_axis_cnt u_vcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (standby_i),
    .adv_i    (v_adv),
    .cfg_i    (timing.v),
    .cnt_o    (v_cnt),
    .last_o   (v_last),
    .active_o (v_act),
    .sync_o   (v_sync)
  );

  lcd_out_reg u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blank_i  (standby_i),
    .h_act_i  (h_act),
    .v_act_i  (v_act),
    .h_sync_i (h_sync),
    .v_sync_i (v_sync),
    .x_i      (h_cnt),
    .y_i      (v_cnt),
    .de_o     (de_o),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .x_o      (x_o),
    .y_o      (y_o)
  );

endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk
  import lcd_timing_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          standby_i,
  input logic          frame_last_i,
  input logic          de_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [CW-1:0] x_o,
  input logic [CW-1:0] y_o,
  input logic          mode_err_o,
  input logic [MW-1:0] active_mode_o
);

  a_r2_x_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && !standby_i) |=> (x_o == $past(x_o) + 11'd1));

  a_r3_de_not_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (!hsync_o && !vsync_o));

  a_r4_hsync_one_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |=> !hsync_o);

  a_r8_illegal_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_err_o) |-> $stable(active_mode_o));

  a_r9_mode_only_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !frame_last_i) |=> $stable(active_mode_o));

  a_r10_standby_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!de_o && !hsync_o && !vsync_o && x_o == '0 && y_o == '0));

endmodule

bind lcd_timing_gen lcd_timing_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .standby_i     (standby_i),
  .frame_last_i  (frame_last),
  .de_o          (de_o),
  .hsync_o       (hsync_o),
  .vsync_o       (vsync_o),
  .x_o           (x_o),
  .y_o           (y_o),
  .mode_err_o    (mode_err_o),
  .active_mode_o (active_mode_o)
);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;

  localparam int WDOG = 195000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [2:0]  code;
  logic        stby;
  logic        hs, vs, de, err;
  logic [10:0] x, y;
  logic [2:0]  am;

  lcd_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_code_i(code), .standby_i(stby),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .x_o(x), .y_o(y),
    .mode_err_o(err), .active_mode_o(am)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int hact, hfp, hsw, hbp, vact, vfp, vsw, vbp, htot, vtot;
  int ex, ey, exp_act, exp_err;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic load(int c);
    case (c)
      7: begin hact=800; hfp=40; hsw=1; hbp=216; vact=480; vfp=10; vsw=1; vbp=35; end
      6: begin hact=640; hfp=24; hsw=1; hbp=136; vact=480; vfp=18; vsw=1; vbp=27; end
      5: begin hact=480; hfp=2;  hsw=1; hbp=43;  vact=272; vfp=2;  vsw=1; vbp=12; end
      4: begin hact=480; hfp=2;  hsw=1; hbp=43;  vact=640; vfp=4;  vsw=1; vbp=8;  end
      default: begin hact=400; hfp=20; hsw=1; hbp=108; vact=240; vfp=2; vsw=1; vbp=20; end
    endcase
    htot = hact + hfp + hsw + hbp;
    vtot = vact + vfp + vsw + vbp;
  endtask

  function automatic bit legal(int c);
    return !(c == 2 || c == 3);
  endfunction

  function automatic int alias_of(int c);
    return (c == 1) ? 5 : c;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // walk n cycles comparing every output with the raster model
  task automatic walk(int n, string mtag);
    int bxy = 0, bde = 0, bhs = 0, bvs = 0, bm = 0;
    int fx = -1, fy = -1;
    for (int i = 0; i < n; i++) begin
      bit last;
      bit e_de, e_hs, e_vs;
      step();
      last = (ex == htot-1) && (ey == vtot-1);
      if (last) begin
        if (legal(int'(code))) begin exp_act = alias_of(int'(code)); exp_err = 0; end
        else exp_err = 1;
      end
      e_de = (ex < hact) && (ey < vact);
      e_hs = (ex >= hact+hfp) && (ex < hact+hfp+hsw);
      e_vs = (ey >= vact+vfp) && (ey < vact+vfp+vsw);
      if (int'(x) != ex || int'(y) != ey) begin
        if (bxy == 0) begin fx = ex; fy = ey; end
        bxy++;
      end
      if (de !== e_de) bde++;
      if (hs !== e_hs) bhs++;
      if (vs !== e_vs) bvs++;
      if (int'(am) != exp_act || int'(err) != exp_err) bm++;
      if (last) begin
        load(exp_act);
        ex = 0; ey = 0;
      end else begin
        ex++;
        if (ex == htot) begin ex = 0; ey++; end
      end
    end
    if (bxy != 0) $display("  first coordinate mismatch at model x=%0d y=%0d", fx, fy);
    chk(bxy == 0, "R2", "coordinate mismatches", bxy, 0);
    chk(bde == 0, "R3", "data enable mismatches", bde, 0);
    chk(bhs == 0, "R4", "hsync mismatches", bhs, 0);
    chk(bvs == 0, "R5", "vsync mismatches", bvs, 0);
    chk(bm == 0, mtag, "mode/error mismatches", bm, 0);
  endtask

  task automatic enter(int c, string tag);
    stby = 1'b1;
    code = 3'(c);
    step();
    chk(!de && !hs && !vs && x == 0 && y == 0, "R10", "outputs blanked in standby",
        int'({de, hs, vs}), 0);
    if (legal(c)) begin exp_act = alias_of(c); exp_err = 0; end
    else exp_err = 1;
    chk(int'(am) == exp_act, tag, "active mode", int'(am), exp_act);
    chk(int'(err) == exp_err, tag, "error flag", int'(err), exp_err);
    stby = 1'b0;
    load(exp_act);
    ex = 0; ey = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stby = 1'b0; code = 3'd7;
    repeat (3) step();
    chk(!de && !hs && !vs && x == 0 && y == 0, "R1", "outputs in reset", int'({de, hs, vs}), 0);
    chk(am == 3'd7, "R1", "reset mode", int'(am), 7);
    chk(err == 1'b0, "R1", "reset error flag", int'(err), 0);
    rst_n = 1'b1;
    exp_act = 7; exp_err = 0; load(7); ex = 0; ey = 0;
    walk(2 * 1057 + 3, "R6");
  endtask

  task automatic t_modes();
    enter(6, "R6"); walk(2 * 801, "R6");
    enter(5, "R6"); walk(2 * 526, "R6");
    enter(4, "R6"); walk(2 * 526, "R6");
    enter(0, "R6"); walk(2 * 529, "R6");
    enter(1, "R7"); walk(530, "R7");
    chk(am == 3'd5, "R7", "aliased mode", int'(am), 5);
  endtask

  task automatic t_illegal();
    enter(7, "R6");
    enter(2, "R8"); walk(1060, "R8");
    chk(am == 3'd7, "R8", "mode kept after code 2", int'(am), 7);
    enter(3, "R8"); walk(900, "R8");
    enter(6, "R11"); walk(810, "R11");
    chk(err == 1'b0, "R11", "error cleared", int'(err), 0);
  endtask

  task automatic t_standby();
    enter(7, "R6");
    walk(1500, "R9");
    stby = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (i == 10) code = 3'd4;
      step();
      chk(!de && !hs && !vs && x == 0 && y == 0, "R10", "parked in standby",
          int'(x) + int'(y), 0);
    end
    chk(am == 3'd4, "R10", "code sampled during standby", int'(am), 4);
    exp_act = 4; exp_err = 0;
    stby = 1'b0;
    load(4); ex = 0; ey = 0;
    walk(600, "R10");
  endtask

  task automatic t_frame();
    enter(0, "R6");
    walk(1000, "R9");
    code = 3'd5;
    walk(50000, "R9");
    chk(am == 3'd0, "R9", "mid-frame code ignored", int'(am), 0);
    code = 3'd3;
    walk(529 * 263 - 51000 + 529, "R8");
    chk(am == 3'd0, "R8", "mode kept at boundary", int'(am), 0);
    chk(err == 1'b1, "R8", "error at boundary", int'(err), 1);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_illegal();
    t_standby();
    t_frame();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", WDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule